// File: doc/BRIEF.md
# Vetoed Downscaled Trigger Former

This block forms a single acquisition trigger from three pre-qualified detector strobes (a neutron-detector OR, a scintillator OR and a scintillator majority) and a test-pulse strobe. Each detector strobe passes through its own programmable divider, so that only every N-th pulse of that source can start a trigger. The test strobe is never divided. Whenever any enabled line of a 32-line veto group is high, every source is blocked. Blocked pulses are also not counted by the dividers.

An accepted trigger is stretched to a programmable number of clock cycles. While the stretched output is high, further triggers are dropped. A second output marks every M-th accepted trigger, using a separate divider. This output can be used to force a readout. A registered monitor output shows the state of the internal veto. The settings are held in a small bank of registers with write access only, and each register has a defined reset value.

Every input strobe counts as one pulse for each clock cycle in which it is high. Producing the qualified detector strobes is done outside this block.

Top module: `trig_former`

## Requirements
- R1: After reset `trig_o`, `rd_trig_o` and `veto_mon_o` are low. The register defaults are: all three source divide factors 1, length value 39 (a 40-cycle output), readout divide factor 32, and all veto enables 0.
- R2: A non-vetoed test pulse, or a pulse that a source divider passes, raises `trig_o` in the cycle after the input cycle. Pulses in the same cycle from several sources give one trigger.
- R3: A source divider with factor N passes the 1st, (N+1)th, (2N+1)th … counted pulse of its source, starting from reset. A factor of 0 acts as 1. The three sources count independently, and test pulses are not counted.
- R4: When `veto_i[i]` is high and enable bit i is 1 in a cycle, no trigger starts from that cycle's pulses. A veto line whose enable bit is 0 has no effect.
- R5: A source pulse that arrives in a vetoed cycle does not advance that source's divider.
- R6: Once started, `trig_o` stays high for exactly L+1 cycles, where L is the length register value at the start.
- R7: A trigger condition that occurs while `trig_o` is high is dropped and does not extend the output. Source pulses in that interval are still counted by their dividers.
- R8: `rd_trig_o` is high for the whole of every M-th started trigger (1st, (M+1)th, …) and low otherwise. M is the readout divide factor, and 0 acts as 1.
- R9: `veto_mon_o` is high in the cycle after a cycle in which some enabled veto line was high, and low otherwise.
- R10: A write with `cfg_we_i` high takes effect from the next cycle. The addresses are: 0 neutron factor, 1 scintillator factor, 2 majority factor, 3 length, 4 readout factor, 5 veto enables [15:0], 6 veto enables [31:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | 16 | Register write data |
| neut_i | input | 1 | Neutron-detector OR strobe |
| scint_i | input | 1 | Scintillator OR strobe |
| maj_i | input | 1 | Scintillator majority strobe |
| test_i | input | 1 | Test-pulse strobe |
| veto_i | input | 32 | Veto lines |
| trig_o | output | 1 | Stretched trigger |
| rd_trig_o | output | 1 | Readout-forcing trigger copy |
| veto_mon_o | output | 1 | Internal veto monitor |

## Verification
Each source is swept through divide factors 0 to 4, with a train of isolated pulses and a test pulse placed among them. This shows whether the divider phase starts with the first pulse and whether test pulses leak into the counters. A walk of a single veto bit over all 32 lines, under an alternating enable mask, checks that enabled and disabled lines are told apart. The state of the veto monitor is checked alongside. Three further patterns are used. A vetoed pulse placed inside a divide-by-2 train shows whether blocked pulses are counted. Pulses sent while the output is stretched show whether they extend the output and whether they are still counted. All sources strobed in one cycle must give exactly one trigger.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int NumSrc  = 3;
  localparam int CfgAddrW = 3;

  typedef enum logic [CfgAddrW-1:0] {
    CFG_NEUT_DIV  = 3'd0,
    CFG_SCINT_DIV = 3'd1,
    CFG_MAJ_DIV   = 3'd2,
    CFG_OUT_LEN   = 3'd3,
    CFG_RD_DIV    = 3'd4,
    CFG_VETO_LO   = 3'd5,
    CFG_VETO_HI   = 3'd6
  } cfg_addr_e;

  localparam logic [15:0] DefSrcDiv = 16'd1;
  localparam logic [15:0] DefOutLen = 16'd39;
  localparam logic [15:0] DefRdDiv  = 16'd32;
endpackage

// File: rtl/trig_cfg.sv
module trig_cfg
  import trig_pkg::*;
#(
  parameter int CFG_W  = 16,
  parameter int VETO_W = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [CfgAddrW-1:0]              addr_i,
  input  logic [CFG_W-1:0]                 wdata_i,
  output logic [NumSrc-1:0][CFG_W-1:0]     src_div_o,
  output logic [CFG_W-1:0]                 out_len_o,
  output logic [CFG_W-1:0]                 rd_div_o,
  output logic [VETO_W-1:0]                veto_en_o
);
  localparam int VetoWords = (VETO_W + CFG_W - 1) / CFG_W;

  logic [VetoWords*CFG_W-1:0] veto_en_q;

  for (genvar s = 0; s < NumSrc; s++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        src_div_o[s] <= CFG_W'(DefSrcDiv);
      else if (we_i && addr_i == CfgAddrW'(int'(CFG_NEUT_DIV) + s))
        src_div_o[s] <= wdata_i;
    end
  end

  for (genvar w = 0; w < VetoWords; w++) begin : g_veto
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        veto_en_q[w*CFG_W +: CFG_W] <= '0;
      else if (we_i && addr_i == CfgAddrW'(int'(CFG_VETO_LO) + w))
        veto_en_q[w*CFG_W +: CFG_W] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_len_o <= CFG_W'(DefOutLen);
      rd_div_o  <= CFG_W'(DefRdDiv);
    end else if (we_i) begin
      if (addr_i == CFG_OUT_LEN) out_len_o <= wdata_i;
      if (addr_i == CFG_RD_DIV)  rd_div_o  <= wdata_i;
    end
  end

  assign veto_en_o = veto_en_q[VETO_W-1:0];
endmodule

// File: rtl/trig_downscaler.sv
module trig_downscaler #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] factor_i,
  input  logic             pulse_i,
  output logic             pass_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  // factor 0 behaves as 1
  assign lim    = (factor_i == '0) ? '0 : factor_i - CNT_W'(1);
  assign pass_o = pulse_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      cnt_q <= '0;
    else if (pulse_i)
      cnt_q <= (cnt_q >= lim) ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/trig_stretch.sv
module trig_stretch #(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             rd_sel_i,
  output logic             fire_o,
  output logic             busy_o,
  output logic             rd_o
);
  logic             busy_q, rd_q;
  logic [LEN_W-1:0] rem_q;

  assign fire_o = start_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      rem_q  <= '0;
    end else if (fire_o) begin
      busy_q <= 1'b1;
      rd_q   <= rd_sel_i;
      rem_q  <= len_i;
    end else if (busy_q) begin
      if (rem_q == '0) begin
        busy_q <= 1'b0;
        rd_q   <= 1'b0;
      end else begin
        rem_q <= rem_q - LEN_W'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign rd_o   = rd_q;
endmodule

// File: rtl/trig_former.sv
module trig_former
  import trig_pkg::*;
#(
  parameter int CFG_W  = 16,
  parameter int VETO_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [CfgAddrW-1:0] cfg_addr_i,
  input  logic [CFG_W-1:0]    cfg_wdata_i,
  input  logic                neut_i,
  input  logic                scint_i,
  input  logic                maj_i,
  input  logic                test_i,
  input  logic [VETO_W-1:0]   veto_i,
  output logic                trig_o,
  output logic                rd_trig_o,
  output logic                veto_mon_o
);
  logic [NumSrc-1:0][CFG_W-1:0] src_div;
  logic [CFG_W-1:0]             out_len, rd_div;
  logic [VETO_W-1:0]            veto_en;
  logic [NumSrc-1:0]            src_raw, src_ok, src_pass;
  logic                         veto_act, hit, fire, rd_pass, veto_mon_q;

  trig_cfg #(.CFG_W(CFG_W), .VETO_W(VETO_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .src_div_o (src_div),
    .out_len_o (out_len),
    .rd_div_o  (rd_div),
    .veto_en_o (veto_en)
  );

  assign veto_act = |(veto_i & veto_en);
  assign src_raw  = {maj_i, scint_i, neut_i};
  assign src_ok   = src_raw & {NumSrc{!veto_act}};

  for (genvar s = 0; s < NumSrc; s++) begin : g_div
    trig_downscaler #(.CNT_W(CFG_W)) u_div (
      .clk_i, .rst_ni,
      .factor_i (src_div[s]),
      .pulse_i  (src_ok[s]),
      .pass_o   (src_pass[s])
    );
  end

  assign hit = (|src_pass) || (test_i && !veto_act);

  trig_stretch #(.LEN_W(CFG_W)) u_stretch (
    .clk_i, .rst_ni,
    .start_i  (hit),
    .len_i    (out_len),
    .rd_sel_i (rd_pass),
    .fire_o   (fire),
    .busy_o   (trig_o),
    .rd_o     (rd_trig_o)
  );

  trig_downscaler #(.CNT_W(CFG_W)) u_rd_div (
    .clk_i, .rst_ni,
    .factor_i (rd_div),
    .pulse_i  (fire),
    .pass_o   (rd_pass)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) veto_mon_q <= 1'b0;
    else         veto_mon_q <= veto_act;
  end
  assign veto_mon_o = veto_mon_q;
endmodule

// File: rtl/trig_former_chk.sv
module trig_former_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             test_i,
  input logic             trig_o,
  input logic             rd_trig_o,
  input logic             fire_i,
  input logic             veto_act_i,
  input logic [LEN_W-1:0] out_len_i
);
  logic [LEN_W:0]   hi_cnt;
  logic [LEN_W-1:0] len_cap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt  <= '0;
      len_cap <= '0;
    end else if (fire_i) begin
      hi_cnt  <= '0;
      len_cap <= out_len_i;
    end else if (trig_o) begin
      hi_cnt <= hi_cnt + 1'b1;
    end
  end

  p_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(trig_o) |-> hi_cnt == {1'b0, len_cap} + 1'b1);

  p_veto_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    veto_act_i |=> !$rose(trig_o));

  p_test_starts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i && !veto_act_i && !trig_o |=> trig_o);

  p_rd_inside_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_trig_o |-> trig_o);

  p_rd_steady_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o && $past(trig_o) |-> rd_trig_o == $past(rd_trig_o));
endmodule

bind trig_former trig_former_chk #(.LEN_W(CFG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .test_i     (test_i),
  .trig_o     (trig_o),
  .rd_trig_o  (rd_trig_o),
  .fire_i     (fire),
  .veto_act_i (veto_act),
  .out_len_i  (out_len)
);

// File: tb/trig_former_tb.sv
module trig_former_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_addr_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic        neut_i = 0, scint_i = 0, maj_i = 0, test_i = 0;
  logic [31:0] veto_i = '0;
  logic        trig_o, rd_trig_o, veto_mon_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  int k_cnt [3];
  int eff [3];
  int t_cnt, rd_eff, cur_len;
  logic [31:0] en_m;

  always #2.5 clk_i = ~clk_i;

  trig_former u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    for (int s = 0; s < 3; s++) begin k_cnt[s] = 0; eff[s] = 1; end
    t_cnt = 0; rd_eff = 32; cur_len = 39; en_m = '0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_addr_i = 3'(a); cfg_wdata_i = 16'(d);
    @(negedge clk_i);
    cfg_we_i = 0;
    case (a)
      0, 1, 2: eff[a] = (d == 0) ? 1 : d;
      3: cur_len = d;
      4: rd_eff = (d == 0) ? 1 : d;
      5: en_m[15:0] = 16'(d);
      6: en_m[31:16] = 16'(d);
      default: ;
    endcase
  endtask

  // srcs: bit0 neut, bit1 scint, bit2 maj, bit3 test
  task automatic predict(input logic [3:0] srcs, input logic [31:0] v,
                         output bit et, output bit er, output bit ev);
    bit vetoed, hit;
    vetoed = |(v & en_m);
    hit = srcs[3] && !vetoed;
    for (int s = 0; s < 3; s++)
      if (srcs[s] && !vetoed) begin
        if (k_cnt[s] % eff[s] == 0) hit = 1;
        k_cnt[s]++;
      end
    et = hit; er = 0; ev = vetoed;
    if (hit) begin
      er = (t_cnt % rd_eff == 0);
      t_cnt++;
    end
  endtask

  task automatic stim(input logic [3:0] srcs, input logic [31:0] v, input string req);
    bit et, er, ev;
    predict(srcs, v, et, er, ev);
    @(negedge clk_i);
    {test_i, maj_i, scint_i, neut_i} = srcs; veto_i = v;
    @(negedge clk_i);
    {test_i, maj_i, scint_i, neut_i} = '0; veto_i = '0;
    chk(trig_o == et, {req, " trig"}, trig_o, et);
    chk(rd_trig_o == er, {req, " rd"}, rd_trig_o, er);
    chk(veto_mon_o == ev, {req, " vmon"}, veto_mon_o, ev);
    repeat (cur_len + 2) @(negedge clk_i);
    chk(trig_o == 0, {req, " idle"}, trig_o, 0);
  endtask

  task automatic measure(output int n);
    @(negedge clk_i); test_i = 1;
    @(negedge clk_i); test_i = 0;
    n = 0;
    while (trig_o && n < 200) begin n++; @(negedge clk_i); end
    repeat (2) @(negedge clk_i);
    t_cnt++;
  endtask

  initial begin
    int n;
    do_reset();
    // R1 reset state and defaults
    chk(trig_o == 0 && rd_trig_o == 0 && veto_mon_o == 0, "R1 reset outputs", trig_o, 0);
    stim(4'b0001, '0, "R1 default neut factor 1");
    stim(4'b0001, '0, "R1 default rd factor 32");
    measure(n);
    chk(n == 40, "R1 default length", n, 40);
    // R4 disabled veto lines have no effect
    stim(4'b1000, 32'hFFFF_FFFF, "R4 disabled veto ignored");

    // R6 length sweep
    for (int l = 0; l < 4; l++) begin
      wr(3, l);
      measure(n);
      chk(n == l + 1, "R6 length", n, l + 1);
    end

    // R3 R8 R10 divider sweep per source
    for (int s = 0; s < 3; s++)
      for (int f = 0; f < 5; f++) begin
        do_reset();
        wr(3, 2); wr(4, 3); wr(s, f);
        for (int p = 0; p < 7; p++) begin
          stim(4'(1 << s), '0, "R3 source divider");
          if (p == 2) stim(4'b1000, '0, "R8 test among pulses");
        end
      end

    // R4 R9 veto walk with alternating enables
    do_reset();
    wr(3, 1); wr(5, 16'h5555); wr(6, 16'h5555);
    for (int i = 0; i < 32; i++) stim(4'b1000, 32'(1) << i, "R4 R9 veto walk");

    // R5 vetoed pulses not counted
    do_reset();
    wr(3, 1); wr(0, 2); wr(5, 1);
    stim(4'b0001, '0, "R5 first");
    stim(4'b0001, 32'h1, "R5 vetoed");
    stim(4'b0001, '0, "R5 second");
    stim(4'b0001, '0, "R5 third");

    // R2 simultaneous sources give one trigger
    do_reset();
    wr(3, 1); wr(4, 2);
    stim(4'b1111, '0, "R2 all sources");
    stim(4'b0110, '0, "R2 two sources");
    stim(4'b1111, '0, "R2 all sources again");

    // R7 no retrigger, pulses still counted
    do_reset();
    wr(3, 5); wr(0, 2);
    @(negedge clk_i); test_i = 1;
    @(negedge clk_i); test_i = 0;
    n = 0;
    while (trig_o && n < 50) begin
      n++;
      if (n == 2) begin test_i = 1; neut_i = 1; end
      else begin test_i = 0; neut_i = 0; end
      @(negedge clk_i);
    end
    test_i = 0; neut_i = 0;
    chk(n == 6, "R7 not extended", n, 6);
    repeat (2) @(negedge clk_i);
    k_cnt[0] = 1; t_cnt = 1;
    stim(4'b0001, '0, "R7 busy pulse counted");
    stim(4'b0001, '0, "R7 next pulse passes");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule